// File: doc/BRIEF.md
# Double-Buffered Mixer Control Registers

This block is the global configuration register set of a display mixer. Software writes the mixer enable, the write-back port select and the output size into shadow registers. The mixing pipeline never sees those values directly. It sees an active copy. The shadow values move into the active copy only when software has requested an apply and the pipeline then reports the end of a frame. A setting therefore never changes in the middle of a frame.

The block also keeps two interrupt flags, one for frame finish and one for pipeline error. Each flag is set by its event whatever its enable holds, and software clears it by writing 1 to it. The interrupt line is raised by any flag whose enable is set. The interrupt enables themselves act at once and are not double-buffered.

A status word reports the two flags, a busy bit and a sticky error indication for the current frame. The register port is a single-cycle 32-bit write strobe with a combinational read path. The pipeline drives three one-cycle pulses: frame start, frame done and error event.

Top module: `mix_cfg_regs`

## Requirements
- R1: After reset, every register reads zero, `mix_en_o`, `wb_port_o`, `out_width_o`, `out_height_o` and `irq_o` are zero, and no apply is pending.
- R2: Control (offset 0x0, bit 0 mixer enable, bit 4 finish-irq enable, bit 5 error-irq enable, bits 13:12 write-back port) and size (offset 0xC, width-1 in bits 12:0, height-1 in bits 28:16) read back the shadow value written. The active outputs do not change until an apply has completed.
- R3: Writing 1 to bit 0 at offset 0x8 sets a pending apply. The pending apply reads back as 1 in bit 0 of 0x8 until the next frame-done pulse. Writing 0 there has no effect.
- R4: A frame-done pulse while an apply is pending copies the shadow enable, port, width and height to the outputs in the next cycle and clears the pending bit.
- R5: A frame-done pulse with no apply pending leaves the active outputs unchanged.
- R6: An apply write in the same cycle as a frame-done pulse does not transfer. It stays pending until the following frame-done.
- R7: Status bit 0 (finish flag) is set by frame-done and status bit 1 (error flag) by an error event, whatever the enables hold. Writing 1 to a flag bit at offset 0x4 clears it. A set in the same cycle as a clear wins.
- R8: `irq_o` is high exactly when some flag is set together with its enable (bit 4 for finish, bit 5 for error). Enable writes act without an apply.
- R9: Status bit 4 (busy) reads 1 only while the active mixer enable is set and a frame is in progress, from the cycle after frame-start up to the frame-done pulse.
- R10: Status bit 5 (error status) is set by an error event and cleared by the next frame-start. An error event in the same cycle as frame-start keeps it set.
- R11: Reserved bits read as zero. A write to an unaligned address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| frame_start_i | input | 1 | Pulse at the start of a frame |
| frame_done_i | input | 1 | Pulse at the end of a frame |
| err_ev_i | input | 1 | Pipeline error event pulse |
| mix_en_o | output | 1 | Active mixer enable |
| wb_port_o | output | 2 | Active write-back port select |
| out_width_o | output | 13 | Active output width minus one |
| out_height_o | output | 13 | Active output height minus one |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: 13-bit dimensions and a 4-bit byte address. At these widths the extreme size values 0 and 0x1FFF (1 and 8192 pixels) can be driven and read back. The unaligned addresses inside the 16-byte window can also be reached to show that such writes are dropped. Walking a table of control and size settings through the write, apply and frame-done sequence shows that outputs hold their old values until the frame boundary. Directed cases cover same-cycle collisions between apply and frame-done, between flag set and flag clear, and between error and frame-start.

// File: rtl/mix_cfg_pkg.sv
package mix_cfg_pkg;
  localparam int unsigned DIM_W   = 13;
  localparam int unsigned H_LSB   = 16;
  localparam int unsigned WB_LSB  = 12;
  localparam int unsigned FIE_BIT = 4;
  localparam int unsigned EIE_BIT = 5;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_APPLY = 2'd2,
    SEL_SIZE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [1:0]       wb;
    logic [DIM_W-1:0] w;
    logic [DIM_W-1:0] h;
  } cfg_t;
endpackage

// File: rtl/mix_cfg_shadow.sv
module mix_cfg_shadow
  import mix_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_ctl_i,
  input  logic        wr_size_i,
  input  logic        wr_apply_i,
  input  logic [31:0] wdata_i,
  input  logic        frame_done_i,
  output cfg_t        shd_o,
  output cfg_t        act_o,
  output logic [1:0]  irq_en_o,
  output logic        pend_o
);
  cfg_t       shd_q, act_q;
  logic [1:0] ien_q;
  logic       pend_q;
  logic       xfer;

  assign xfer = pend_q & frame_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_ctl_i) begin
        shd_q.en <= wdata_i[0];
        shd_q.wb <= wdata_i[WB_LSB +: 2];
        ien_q    <= {wdata_i[EIE_BIT], wdata_i[FIE_BIT]};
      end
      if (wr_size_i) begin
        shd_q.w <= wdata_i[DIM_W-1:0];
        shd_q.h <= wdata_i[H_LSB +: DIM_W];
      end
    end
  end

  // transfer uses the shadow as it stood before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= '0;
    else if (xfer) act_q <= shd_q;
  end

  // a new request in the transfer cycle survives to the next frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (wr_apply_i && wdata_i[0])  pend_q <= 1'b1;
    else if (xfer)                      pend_q <= 1'b0;
  end

  assign shd_o    = shd_q;
  assign act_o    = act_q;
  assign irq_en_o = ien_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/mix_cfg_irq.sv
module mix_cfg_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stat_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] irq_en_i,
  input  logic       frame_start_i,
  input  logic       frame_done_i,
  input  logic       err_ev_i,
  output logic [1:0] flags_o,
  output logic       err_stat_o,
  output logic       irq_o
);
  logic [1:0] flags_q, set_v, clr_v;
  logic       err_q;

  assign set_v = {err_ev_i, frame_done_i};
  assign clr_v = wr_stat_i ? clr_i : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            err_q <= 1'b0;
    else if (err_ev_i)      err_q <= 1'b1;
    else if (frame_start_i) err_q <= 1'b0;
  end

  assign flags_o    = flags_q;
  assign err_stat_o = err_q;
  assign irq_o      = |(flags_q & irq_en_i);
endmodule

// File: rtl/mix_cfg_busy.sv
module mix_cfg_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_en_i,
  input  logic frame_start_i,
  input  logic frame_done_i,
  output logic busy_o
);
  logic in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            in_frame_q <= 1'b0;
    else if (frame_start_i) in_frame_q <= 1'b1;
    else if (frame_done_i)  in_frame_q <= 1'b0;
  end

  assign busy_o = act_en_i & in_frame_q;
endmodule

// File: rtl/mix_cfg_regs.sv
module mix_cfg_regs
  import mix_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic              err_ev_i,
  output logic              mix_en_o,
  output logic [1:0]        wb_port_o,
  output logic [DIM_W-1:0]  out_width_o,
  output logic [DIM_W-1:0]  out_height_o,
  output logic              irq_o
);
  localparam int unsigned SEL_LSB = 2;

  logic       aligned, hit;
  reg_sel_e   sel;
  logic       wr_ctl, wr_stat, wr_apply, wr_size;
  cfg_t       shd, act;
  logic [1:0] irq_en, flags;
  logic       pend, busy, err_stat;

  assign sel     = reg_sel_e'(reg_addr_i[SEL_LSB +: 2]);
  assign aligned = (reg_addr_i[SEL_LSB-1:0] == '0);

  generate
    if (ADDR_W > SEL_LSB + 2) begin : g_hi
      assign hit = aligned && (reg_addr_i[ADDR_W-1:SEL_LSB+2] == '0);
    end else begin : g_nohi
      assign hit = aligned;
    end
  endgenerate

  assign wr_ctl   = reg_wr_i && hit && (sel == SEL_CTL);
  assign wr_stat  = reg_wr_i && hit && (sel == SEL_STAT);
  assign wr_apply = reg_wr_i && hit && (sel == SEL_APPLY);
  assign wr_size  = reg_wr_i && hit && (sel == SEL_SIZE);

  mix_cfg_shadow u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctl_i    (wr_ctl),
    .wr_size_i   (wr_size),
    .wr_apply_i  (wr_apply),
    .wdata_i     (reg_wdata_i),
    .frame_done_i(frame_done_i),
    .shd_o       (shd),
    .act_o       (act),
    .irq_en_o    (irq_en),
    .pend_o      (pend)
  );

  mix_cfg_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_stat_i    (wr_stat),
    .clr_i        (reg_wdata_i[1:0]),
    .irq_en_i     (irq_en),
    .frame_start_i(frame_start_i),
    .frame_done_i (frame_done_i),
    .err_ev_i     (err_ev_i),
    .flags_o      (flags),
    .err_stat_o   (err_stat),
    .irq_o        (irq_o)
  );

  mix_cfg_busy u_busy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_en_i     (act.en),
    .frame_start_i(frame_start_i),
    .frame_done_i (frame_done_i),
    .busy_o       (busy)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_CTL: begin
          reg_rdata_o[0]            = shd.en;
          reg_rdata_o[FIE_BIT]      = irq_en[0];
          reg_rdata_o[EIE_BIT]      = irq_en[1];
          reg_rdata_o[WB_LSB +: 2]  = shd.wb;
        end
        SEL_STAT: begin
          reg_rdata_o[1:0] = flags;
          reg_rdata_o[4]   = busy;
          reg_rdata_o[5]   = err_stat;
        end
        SEL_APPLY: reg_rdata_o[0] = pend;
        SEL_SIZE: begin
          reg_rdata_o[DIM_W-1:0]      = shd.w;
          reg_rdata_o[H_LSB +: DIM_W] = shd.h;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign mix_en_o     = act.en;
  assign wb_port_o    = act.wb;
  assign out_width_o  = act.w;
  assign out_height_o = act.h;
endmodule

// File: rtl/mix_cfg_regs_chk.sv
module mix_cfg_regs_chk
  import mix_cfg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_done_i,
  input logic       err_ev_i,
  input logic       pend,
  input cfg_t       shd,
  input cfg_t       act,
  input logic [1:0] flags,
  input logic       busy,
  input logic       irq_o,
  input logic       mix_en_o
);
  assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && !frame_done_i |=> pend);

  assert_xfer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend && frame_done_i |=> act == $past(shd));

  assert_act_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend && frame_done_i) |=> $stable(act));

  assert_err_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i |=> flags[1]);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != 2'b00));

  assert_busy_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> mix_en_o);
endmodule

bind mix_cfg_regs mix_cfg_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_done_i(frame_done_i),
  .err_ev_i    (err_ev_i),
  .pend        (pend),
  .shd         (shd),
  .act         (act),
  .flags       (flags),
  .busy        (busy),
  .irq_o       (irq_o),
  .mix_en_o    (mix_en_o)
);

// File: tb/mix_cfg_regs_bench.sv
module mix_cfg_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // {ctl word, size word}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_1001, 32'h1FFF_1FFF},
    {32'h0000_2000, 32'h0000_0000},
    {32'h0000_3001, 32'h0437_077F},
    {32'h0000_0001, 32'h02CF_04FF}
  };

  logic        clk = 0, rst_ni = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fs = 0, fd = 0, ev = 0;
  logic        mix_en, irq;
  logic [1:0]  wb;
  logic [12:0] ow, oh;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  mix_cfg_regs u_mix_cfg_regs (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .frame_start_i(fs),
    .frame_done_i(fd), .err_ev_i(ev), .mix_en_o(mix_en), .wb_port_o(wb),
    .out_width_o(ow), .out_height_o(oh), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at negedge, one posedge passes, return at next negedge
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic s, input logic dn, input logic e);
    reg_wr = wr; reg_addr = a; reg_wdata = d; fs = s; fd = dn; ev = e;
    @(negedge clk);
    reg_wr = 0; fs = 0; fd = 0; ev = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] outs();
    return {mix_en, 1'b0, wb, 1'b0, oh, 1'b0, ow};
  endfunction

  function automatic logic [31:0] exp_outs(input logic [31:0] c, input logic [31:0] s);
    return {c[0], 1'b0, c[13:12], 1'b0, s[28:16], 1'b0, s[12:0]};
  endfunction

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(4'h0, rv); chk("R1 ctl", rv, 0);
    rd(4'h4, rv); chk("R1 stat", rv, 0);
    rd(4'h8, rv); chk("R1 apply", rv, 0);
    rd(4'hC, rv); chk("R1 size", rv, 0);
    chk("R1 outs", {outs()[31:1], irq}, 0);
    rst_ni = 1;
    @(negedge clk);

    prev = 0;
    for (int i = 0; i < NVEC; i++) begin
      wr(4'h0, VEC[i][63:32]);
      wr(4'hC, VEC[i][31:0]);
      rd(4'h0, rv); chk("R2 ctl shadow", rv, VEC[i][63:32] & 32'h3031);
      rd(4'hC, rv); chk("R2 size shadow", rv, VEC[i][31:0] & 32'h1FFF_1FFF);
      chk("R2 outs held", outs(), prev);
      cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
      chk("R5 done without apply", outs(), prev);
      wr(4'h8, 32'h1);
      rd(4'h8, rv); chk("R3 pending", rv, 1);
      chk("R3 outs held", outs(), prev);
      cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
      prev = exp_outs(VEC[i][63:32], VEC[i][31:0]);
      chk("R4 transfer", outs(), prev);
      rd(4'h8, rv); chk("R4 pending cleared", rv, 0);
    end

    // R3 writing 0 to apply has no effect
    wr(4'h8, 32'hFFFF_FFFE);
    rd(4'h8, rv); chk("R3 zero write", rv, 0);

    // R6 apply coinciding with frame done
    wr(4'h0, 32'h0000_2000);
    cyc(1'b1, 4'h8, 32'h1, 1'b0, 1'b1, 1'b0);
    chk("R6 no transfer", outs(), prev);
    rd(4'h8, rv); chk("R6 still pending", rv, 1);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
    prev = {1'b0, 1'b0, 2'b10, prev[27:0]};
    chk("R6 later transfer", outs(), prev);

    // R7 flags, R8 irq
    wr(4'h4, 32'h3);
    rd(4'h4, rv); chk("R7 w1c", rv[1:0], 0);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b0, 1'b1);
    rd(4'h4, rv); chk("R7 err flag no enable", rv[1:0], 2'b10);
    chk("R8 irq masked", irq, 0);
    wr(4'h0, 32'h0000_0020);
    chk("R8 irq enable immediate", irq, 1);
    wr(4'h4, 32'h1);
    rd(4'h4, rv); chk("R7 clear other bit only", rv[1:0], 2'b10);
    cyc(1'b1, 4'h4, 32'h2, 1'b0, 1'b0, 1'b1);
    rd(4'h4, rv); chk("R7 set wins", rv[1:0], 2'b10);
    wr(4'h4, 32'h2);
    chk("R8 irq drops", irq, 0);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
    chk("R8 finish masked", irq, 0);
    wr(4'h0, 32'h0000_0010);
    chk("R8 finish irq", irq, 1);
    wr(4'h4, 32'h3);

    // R9 busy: active enable still 0
    cyc(1'b0, 4'h0, 0, 1'b1, 1'b0, 1'b0);
    rd(4'h4, rv); chk("R9 busy needs enable", rv[4], 0);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
    wr(4'h0, 32'h1); wr(4'h8, 32'h1);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
    chk("R4 enable active", mix_en, 1);
    cyc(1'b0, 4'h0, 0, 1'b1, 1'b0, 1'b0);
    rd(4'h4, rv); chk("R9 busy in frame", rv[4], 1);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0);
    rd(4'h4, rv); chk("R9 idle after done", rv[4], 0);

    // R10 error status
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b0, 1'b1);
    rd(4'h4, rv); chk("R10 err status set", rv[5], 1);
    cyc(1'b0, 4'h0, 0, 1'b1, 1'b0, 1'b1);
    rd(4'h4, rv); chk("R10 error beats start", rv[5], 1);
    cyc(1'b0, 4'h0, 0, 1'b1, 1'b0, 1'b0);
    rd(4'h4, rv); chk("R10 cleared by start", rv[5], 0);

    // R11 reserved bits and unaligned writes
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, rv); chk("R11 ctl reserved", rv, 32'h0000_3031);
    wr(4'hD, 32'h0);
    rd(4'hC, rv); chk("R11 unaligned ignored", rv, VEC[NVEC-1][31:0]);
    rd(4'h8, rv); chk("R11 apply reserved", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule